// File: doc/BRIEF.md
# Receive Sampling-Delay Window Tuner

This controller finds a safe receive sampling delay for a fast card interface. It steps a 6-bit delay setting through candidates 0 to NUM_CAND-1 in rising order. For each candidate it loads the value and raises an update strobe. Once the delay line acknowledges the update, the controller asks an external sequencer to run a tuning-block transfer. The sequencer answers with done and pass/fail.

The controller keeps track of the longest unbroken run of passing candidates. When the sweep ends it programs the centre of that run and raises a one-cycle done. If no candidate passed, it raises a one-cycle error instead.

The sweep is deliberately kept below the delay line's wrap point, so no value above NUM_CAND-1 (39 by default) is ever issued.

Top module: `sample_window_tuner`

## Requirements
- R1: After reset, `tap_val` is 0 and `tap_upd`, `test_req`, `done` and `error` are all low.
- R2: A start in idle sweeps candidates 0, 1, … NUM_CAND-1 in order, one apply each. `tap_val` never exceeds NUM_CAND-1.
- R3: During an apply, `tap_upd` stays high with `tap_val` steady until `tap_upd_ack` is seen. `test_req` rises only in the cycle after an acknowledge. It stays high until `test_done`, and `test_pass` is sampled on that same cycle.
- R4: If no acknowledge arrives within UPD_TIMEOUT cycles of an apply (8 by default), that candidate counts as failing. No test is requested for it, and the next candidate is applied at once. An acknowledge in the last cycle of the window still counts.
- R5: A passing candidate extends the current run by one. A failing one, from either a test or a timeout, clears the current run to zero.
- R6: The best run is replaced only by a strictly longer run, so of two equal runs the earlier one is kept.
- R7: When at least one candidate passed, the final value is (end index of the best run) − floor(length / 2). It is applied with the same update handshake. `done` pulses in the cycle after its acknowledge.
- R8: When no candidate passed, `error` pulses after the sweep and no final value is applied. `error` also pulses if the final apply times out.
- R9: `start` is ignored while a search is running. A `start` in the cycle where `done` or `error` is high is accepted and begins a new sweep at candidate 0.
- R10: `done` and `error` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search when idle |
| tap_val | output | VAL_W | Delay value presented to the delay line |
| tap_upd | output | 1 | Update strobe, high while an apply waits for acknowledge |
| tap_upd_ack | input | 1 | Delay line reports the value has taken effect |
| test_req | output | 1 | Request a tuning-block transfer test |
| test_done | input | 1 | Test finished this cycle |
| test_pass | input | 1 | Test result, valid with test_done |
| done | output | 1 | One-cycle pulse: centred value applied |
| error | output | 1 | One-cycle pulse: no window found or final apply failed |

## Verification
Two events can fall in the same cycle: an update acknowledge and the expiry of the update timeout. The bench provokes this by setting the responder latency to exactly UPD_TIMEOUT cycles. It judges the outcome by requiring all 40 tests to be requested and the normal centred result to come out. A latency one cycle longer must instead time out every candidate and end in error with no test. A second coincidence, a fresh start landing in the done cycle, is raised by the bench. The bench then expects an apply of candidate 0 on the next cycle.

// File: rtl/sample_window_tuner.sv
module sample_window_tuner #(
  parameter int NUM_CAND    = 40,
  parameter int VAL_W       = 6,
  parameter int UPD_TIMEOUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [VAL_W-1:0] tap_val,
  output logic             tap_upd,
  input  logic             tap_upd_ack,
  output logic             test_req,
  input  logic             test_done,
  input  logic             test_pass,
  output logic             done,
  output logic             error
);
  localparam int CNT_W = $clog2(UPD_TIMEOUT + 1);
  localparam int LEN_W = $clog2(NUM_CAND + 1);

  typedef enum logic [2:0] {S_IDLE, S_APPLY, S_TEST, S_WRAP, S_FINAL} state_t;
  state_t st;

  logic [VAL_W-1:0] idx, end_idx;
  logic [LEN_W-1:0] cur_len, best_len;
  logic [CNT_W-1:0] tcnt;

  wire [LEN_W-1:0] run_inc = cur_len + LEN_W'(1);
  wire tmo       = (tcnt == CNT_W'(UPD_TIMEOUT - 1)) && !tap_upd_ack;
  wire cand_done = (st == S_APPLY && tmo) || (st == S_TEST && test_done);
  wire cand_ok   = (st == S_TEST) && test_pass;
  wire last_cand = (idx == VAL_W'(NUM_CAND - 1));

  assign tap_upd  = (st == S_APPLY) || (st == S_FINAL);
  assign test_req = (st == S_TEST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      tap_val  <= '0;
      end_idx  <= '0;
      cur_len  <= '0;
      best_len <= '0;
      tcnt     <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          idx      <= '0;
          tap_val  <= '0;
          end_idx  <= '0;
          cur_len  <= '0;
          best_len <= '0;
          tcnt     <= '0;
          st       <= S_APPLY;
        end
        S_APPLY: begin
          if (tap_upd_ack)  st   <= S_TEST;
          else if (!tmo)    tcnt <= tcnt + CNT_W'(1);
        end
        S_WRAP: begin
          if (best_len == '0) begin
            error <= 1'b1;
            st    <= S_IDLE;
          end else begin
            tap_val <= end_idx - VAL_W'(best_len >> 1);
            tcnt    <= '0;
            st      <= S_FINAL;
          end
        end
        S_FINAL: begin
          if (tap_upd_ack) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (tmo) begin
            error <= 1'b1;
            st    <= S_IDLE;
          end else begin
            tcnt <= tcnt + CNT_W'(1);
          end
        end
        default: ;
      endcase

      if (cand_done) begin
        if (cand_ok) begin
          cur_len <= run_inc;
          if (run_inc > best_len) begin
            best_len <= run_inc;
            end_idx  <= idx;
          end
        end else begin
          cur_len <= '0;
        end
        if (last_cand) begin
          st <= S_WRAP;
        end else begin
          idx     <= idx + VAL_W'(1);
          tap_val <= idx + VAL_W'(1);
          tcnt    <= '0;
          st      <= S_APPLY;
        end
      end
    end
  end
endmodule

// File: rtl/sample_window_tuner_chk.sv
module sample_window_tuner_chk #(
  parameter int NUM_CAND = 40,
  parameter int VAL_W    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [VAL_W-1:0] tap_val,
  input logic             tap_upd,
  input logic             tap_upd_ack,
  input logic             test_req,
  input logic             test_done,
  input logic             test_pass,
  input logic             done,
  input logic             error
);
  p_tap_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_val <= VAL_W'(NUM_CAND - 1));

  p_test_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_req) |-> ($past(tap_upd) && $past(tap_upd_ack)));

  p_ack_ends_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_upd && tap_upd_ack) |=> (!tap_upd && (test_req || done)));

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tap_upd && test_req));

  p_done_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(tap_upd) && $past(tap_upd_ack)));

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_error_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);
endmodule

bind sample_window_tuner sample_window_tuner_chk #(.NUM_CAND(NUM_CAND), .VAL_W(VAL_W)) u_chk (.*);

// File: tb/tb_sample_window_tuner.sv
`timescale 1ns/1ps
module tb_sample_window_tuner;
  localparam int NC = 40;
  localparam int VW = 6;
  localparam int TO = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [VW-1:0] tap_val;
  logic tap_upd, tap_upd_ack, test_req, test_done, test_pass, done, error;

  always #2.5 clk = ~clk;

  sample_window_tuner #(.NUM_CAND(NC), .VAL_W(VW), .UPD_TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tap_val(tap_val), .tap_upd(tap_upd),
    .tap_upd_ack(tap_upd_ack), .test_req(test_req), .test_done(test_done),
    .test_pass(test_pass), .done(done), .error(error));

  int checks = 0, fails = 0;
  logic [NC-1:0] mask, noack;
  int lat = 2;
  int n_app, n_test, seq_err, rcnt;
  logic [VW-1:0] final_seen, prev_val;
  logic prev_upd;

  // vector: {expect_error, expected_final, pass_mask}
  localparam logic [46:0] VEC [9] = '{
    {1'b0, 6'd19, 40'hFF_FFFF_FFFF},
    {1'b0, 6'd12, 40'h00_0000_7C00},
    {1'b0, 6'd3,  40'h00_00F0_003C},
    {1'b0, 6'd33, 40'h1F_C000_0007},
    {1'b0, 6'd0,  40'h00_0000_0001},
    {1'b0, 6'd39, 40'h80_0000_0000},
    {1'b1, 6'd0,  40'h00_0000_0000},
    {1'b0, 6'd38, 40'hE0_0000_0000},
    {1'b0, 6'd0,  40'h55_5555_5555}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // delay-line and transfer-test responder
  initial begin
    upd_ack_init();
    forever begin
      @(negedge clk);
      tap_upd_ack = 1'b0; test_done = 1'b0; test_pass = 1'b0;
      if (tap_upd) begin
        if (!prev_upd || tap_val != prev_val) begin
          if (n_app < NC && tap_val != VW'(n_app)) seq_err++;
          if (n_app == NC) final_seen = tap_val;
          n_app++;
          rcnt = 1;
        end else rcnt++;
        if (rcnt == lat && !(n_app <= NC && tap_val < VW'(NC) && noack[tap_val]))
          tap_upd_ack = 1'b1;
      end else rcnt = 0;
      if (test_req) begin
        test_done = 1'b1;
        test_pass = (tap_val < VW'(NC)) ? mask[tap_val] : 1'b0;
        n_test++;
      end
      prev_upd = tap_upd;
      prev_val = tap_val;
    end
  end

  task automatic upd_ack_init();
    tap_upd_ack = 1'b0; test_done = 1'b0; test_pass = 1'b0;
    prev_upd = 1'b0; prev_val = '0; rcnt = 0;
  endtask

  task automatic run(input logic [NC-1:0] m, input logic [NC-1:0] na, input int l,
                     input bit mid_start, output bit got_done, output bit got_err);
    int cyc = 0;
    mask = m; noack = na; lat = l;
    n_app = 0; n_test = 0; seq_err = 0; final_seen = '0;
    got_done = 0; got_err = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!(done || error)) begin
      @(negedge clk);
      cyc++;
      if (mid_start) start = (cyc == 50);
      if (cyc > 3000) begin
        check(0, "watchdog", cyc, 3000);
        break;
      end
    end
    start = 1'b0;
    got_done = done; got_err = error;
    @(negedge clk);
    check(!done && !error, "R10 pulse width", int'(done | error), 0);
  endtask

  initial begin
    bit gd, ge;
    n_app = 0; n_test = 0; seq_err = 0; mask = '0; noack = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tap_val == 0 && !tap_upd && !test_req && !done && !error, "R1 reset",
          int'({tap_upd, test_req, done, error}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tap_upd && !test_req, "R1 idle after reset", int'(tap_upd), 0);

    // table of pass masks
    for (int v = 0; v < 9; v++) begin
      run(VEC[v][39:0], '0, 2, 0, gd, ge);
      if (VEC[v][46]) begin
        check(ge && !gd, "R8 no window error", int'(ge), 1);
        check(n_app == NC, "R8 no final apply", n_app, NC);
      end else begin
        check(gd && !ge, "R7 done", int'(gd), 1);
        check(final_seen == VEC[v][45:40], "R5 R6 R7 centred value",
              int'(final_seen), int'(VEC[v][45:40]));
        check(n_app == NC + 1, "R2 apply count", n_app, NC + 1);
      end
      check(seq_err == 0, "R2 sweep order", seq_err, 0);
      check(n_test == NC, "R3 one test per candidate", n_test, NC);
    end

    // R4: candidate 20 never acknowledged -> runs 0..19 and 21..39, centre 9
    run({NC{1'b1}}, 40'h00_0010_0000, 2, 0, gd, ge);
    check(gd && final_seen == 9, "R4 timeout counts as fail", int'(final_seen), 9);
    check(n_test == NC - 1, "R4 no test on timeout", n_test, NC - 1);

    // acknowledge on the last timeout cycle is accepted
    run({NC{1'b1}}, '0, TO, 0, gd, ge);
    check(gd && final_seen == 19, "R4 ack at timeout edge", int'(final_seen), 19);
    check(n_test == NC, "R4 edge tests", n_test, NC);

    // acknowledge one cycle too late: all time out
    run({NC{1'b1}}, '0, TO + 1, 0, gd, ge);
    check(ge && !gd, "R4 R8 all timed out", int'(ge), 1);
    check(n_test == 0, "R4 no tests", n_test, 0);

    // R9: start during sweep ignored
    run({NC{1'b1}}, '0, 2, 1, gd, ge);
    check(gd && final_seen == 19, "R9 mid start ignored result", int'(final_seen), 19);
    check(n_app == NC + 1 && seq_err == 0, "R9 mid start no restart", n_app, NC + 1);

    // R9: start in the done cycle begins a new sweep
    begin
      int cyc = 0;
      mask = {NC{1'b1}}; noack = '0; lat = 2;
      n_app = 0; n_test = 0; seq_err = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
      check(cyc < 3000, "watchdog", cyc, 3000);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(tap_upd && tap_val == 0, "R9 start in done cycle accepted",
            int'(tap_upd), 1);
      cyc = 0;
      while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
      check(done && tap_val == 19, "R9 second sweep result", int'(tap_val), 19);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule